// File: doc/BRIEF.md
# Dual Phase Detector and Lock Monitor

This block serves two frequency synthesizer channels. For each channel it compares a reference event (from the reference divider) with a feedback event (from the programmable divider). It turns their relative timing into up and down commands for a charge pump, plus an enable that takes the pump out of high impedance. Each channel has a three-state detector: the event that arrives first opens a correction pulse, and the arrival of the other event ends it. A per-channel polarity input swaps the up and down commands, so the block can serve a tuning element whose frequency falls as its control voltage rises.

A lock filter per channel measures how long each correction pulse lasts. It declares the channel locked after four consecutive reference periods with narrow pulses. A single shared monitor output shows either the combined lock status of the powered-up channels or one raw divider event, selected by a 3-bit code. All event inputs are single-cycle pulses, already synchronous to `clk`.

Top module: `dual_pfd_lock`

## Requirements
- R1: After reset, and whenever a channel's detector is idle (including when both events arrive in the same cycle), that channel's `up`, `dn` and `drive` are all low; `drive` low means high impedance.
- R2: With polarity 0, a reference event that arrives while the detector is idle and without a feedback event raises `up` and `drive` from the next cycle. A lone feedback event raises `dn` and `drive` from the next cycle.
- R3: While a correction pulse is open, the arrival of the opposite event returns the channel to idle one cycle later.
- R4: With the polarity input at 1, the channel's `up` and `dn` are exchanged. A reference-first pulse then appears on `dn`.
- R5: A powered-up channel becomes locked in the cycle after its fourth consecutive qualifying reference event. A qualifying event is one that arrives while no correction pulse has lasted more than `lock_thresh` cycles. It is not locked after three such events.
- R6: A correction pulse that has lasted more than `lock_thresh` cycles clears the lock flag and the period count on the next edge. A pulse of exactly `lock_thresh + 1` cycles keeps lock for one more cycle and then clears it.
- R7: With `mon_sel` = 3'b000, `mon_out` is the AND of the lock flags of the channels whose power-down input is low. It is low when both channels are powered down.
- R8: `mon_sel` 3'b001 gives `ref_a`, 3'b010 gives `fb_a`, 3'b011 gives `ref_b` and 3'b100 gives `fb_b` at `mon_out`, combinationally. Codes 3'b101 to 3'b111 drive it low.
- R9: A high power-down input forces the channel idle (`drive` low) and its lock flag low from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_a | input | 1 | Channel A reference event, one-cycle pulse |
| fb_a | input | 1 | Channel A feedback divider event |
| ref_b | input | 1 | Channel B reference event |
| fb_b | input | 1 | Channel B feedback divider event |
| invert_a | input | 1 | Channel A pump polarity swap |
| invert_b | input | 1 | Channel B pump polarity swap |
| pwrdn_a | input | 1 | Channel A power-down |
| pwrdn_b | input | 1 | Channel B power-down |
| mon_sel | input | 3 | Monitor output select code |
| lock_thresh | input | 8 | Largest pulse width, in cycles, still counted as narrow |
| up_a | output | 1 | Channel A pump up command |
| dn_a | output | 1 | Channel A pump down command |
| drive_a | output | 1 | Channel A pump enable (low = high impedance) |
| up_b | output | 1 | Channel B pump up command |
| dn_b | output | 1 | Channel B pump down command |
| drive_b | output | 1 | Channel B pump enable |
| mon_out | output | 1 | Shared monitor pin |

## Verification
A detector stuck in a wrong state shows on `up`/`dn`/`drive` on the very next cycle after an event, so each single-event step is checked one edge later. A miscount in the lock filter shows only at the monitor with `mon_sel` = 0. It is therefore probed right at the boundaries: after the third and fourth aligned events, and at `lock_thresh + 1` and `lock_thresh + 2` cycles into a held pulse, where an off-by-one error moves the change by exactly one cycle. Selector faults are combinational and show at once, so the code table is applied with opposite values on the channels that are not selected.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    typedef enum logic [1:0] {
        PFD_IDLE     = 2'd0,
        PFD_LEAD_REF = 2'd1,
        PFD_LEAD_FB  = 2'd2
    } pfd_state_e;

    typedef struct packed {
        pfd_state_e state;
    } pfd_regs_t;
endpackage

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwrdn,
    input  logic ref_evt,
    input  logic fb_evt,
    input  logic invert,
    output logic up,
    output logic dn,
    output logic drive,
    output logic active
);
    pfd_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (pwrdn) begin
            r_d.state = PFD_IDLE;
        end else begin
            unique case (r_q.state)
                PFD_IDLE: begin
                    if (ref_evt && !fb_evt)      r_d.state = PFD_LEAD_REF;
                    else if (fb_evt && !ref_evt) r_d.state = PFD_LEAD_FB;
                end
                PFD_LEAD_REF: if (fb_evt)  r_d.state = PFD_IDLE;
                PFD_LEAD_FB:  if (ref_evt) r_d.state = PFD_IDLE;
                default: r_d.state = PFD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: PFD_IDLE};
        else        r_q <= r_d;
    end

    logic raw_up, raw_dn;
    always_comb begin
        raw_up = (r_q.state == PFD_LEAD_REF);
        raw_dn = (r_q.state == PFD_LEAD_FB);
        up     = invert ? raw_dn : raw_up;
        dn     = invert ? raw_up : raw_dn;
        drive  = raw_up | raw_dn;
        active = drive;
    end

    assert_ref_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwrdn && r_q.state == PFD_IDLE && ref_evt && !fb_evt) |=> (r_q.state == PFD_LEAD_REF));
    assert_fb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwrdn && r_q.state == PFD_IDLE && fb_evt && !ref_evt) |=> (r_q.state == PFD_LEAD_FB));
    assert_second_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == PFD_LEAD_REF && fb_evt) |=> !drive);
    assert_pwrdn_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn |=> !drive);
    assert_polarity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && invert) |-> (dn == (r_q.state == PFD_LEAD_REF)));
endmodule

// File: rtl/lock_filter.sv
module lock_filter #(
    parameter int THRESH_W     = 8,
    parameter int LOCK_PERIODS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwrdn,
    input  logic                ref_evt,
    input  logic                active,
    input  logic [THRESH_W-1:0] thresh,
    output logic                locked
);
    localparam int CNT_W = $clog2(LOCK_PERIODS + 1);
    localparam logic [CNT_W-1:0]    STREAK_MAX = CNT_W'(LOCK_PERIODS);
    localparam logic [THRESH_W:0]   WID_MAX    = '1;

    typedef struct packed {
        logic [THRESH_W:0] wid;
        logic [CNT_W-1:0]  streak;
        logic              locked;
    } lf_regs_t;

    lf_regs_t r_d, r_q;
    logic     too_wide;

    always_comb begin
        r_d      = r_q;
        too_wide = active && (r_q.wid > {1'b0, thresh});
        if (pwrdn) begin
            r_d = '0;
        end else begin
            if (active) r_d.wid = (r_q.wid == WID_MAX) ? WID_MAX : r_q.wid + 1'b1;
            else        r_d.wid = '0;
            if (too_wide) begin
                r_d.streak = '0;
                r_d.locked = 1'b0;
            end else if (ref_evt) begin
                r_d.streak = (r_q.streak == STREAK_MAX) ? STREAK_MAX : r_q.streak + 1'b1;
                if (r_q.streak >= STREAK_MAX - 1'b1) r_d.locked = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign locked = r_q.locked;

    assert_wide_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        too_wide |=> !locked);
    assert_pwrdn_unlock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn |=> !locked);
    assert_lock_on_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(ref_evt));
endmodule

// File: rtl/monitor_select.sv
module monitor_select #(
    parameter int NCH   = 2,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic [NCH-1:0]   ref_evt,
    input  logic [NCH-1:0]   fb_evt,
    input  logic [NCH-1:0]   locked,
    input  logic [NCH-1:0]   pwrdn,
    output logic             mon
);
    localparam int NSRC = 2 * NCH;

    logic [NSRC-1:0] src;
    for (genvar c = 0; c < NCH; c++) begin : g_src
        assign src[2*c]     = ref_evt[c];
        assign src[2*c + 1] = fb_evt[c];
    end

    logic lock_all;
    always_comb begin
        lock_all = (|(~pwrdn)) && (&(locked | pwrdn));
        if (sel == '0)                           mon = lock_all;
        else if (int'(sel) <= NSRC)              mon = src[int'(sel) - 1];
        else                                     mon = 1'b0;
    end

    assert_bad_code_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel) > NSRC) |-> !mon);
    assert_none_powered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0 && (&pwrdn)) |-> !mon);
endmodule

// File: rtl/dual_pfd_lock.sv
module dual_pfd_lock #(
    parameter int THRESH_W     = 8,
    parameter int LOCK_PERIODS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_a,
    input  logic                fb_a,
    input  logic                ref_b,
    input  logic                fb_b,
    input  logic                invert_a,
    input  logic                invert_b,
    input  logic                pwrdn_a,
    input  logic                pwrdn_b,
    input  logic [2:0]          mon_sel,
    input  logic [THRESH_W-1:0] lock_thresh,
    output logic                up_a,
    output logic                dn_a,
    output logic                drive_a,
    output logic                up_b,
    output logic                dn_b,
    output logic                drive_b,
    output logic                mon_out
);
    localparam int NCH = 2;

    logic [NCH-1:0] ref_v, fb_v, inv_v, pd_v, up_v, dn_v, drv_v, act_v, lock_v;

    assign ref_v = {ref_b, ref_a};
    assign fb_v  = {fb_b, fb_a};
    assign inv_v = {invert_b, invert_a};
    assign pd_v  = {pwrdn_b, pwrdn_a};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pfd_core u_core (
            .clk(clk), .rst_n(rst_n), .pwrdn(pd_v[c]),
            .ref_evt(ref_v[c]), .fb_evt(fb_v[c]), .invert(inv_v[c]),
            .up(up_v[c]), .dn(dn_v[c]), .drive(drv_v[c]), .active(act_v[c])
        );
        lock_filter #(.THRESH_W(THRESH_W), .LOCK_PERIODS(LOCK_PERIODS)) u_lock (
            .clk(clk), .rst_n(rst_n), .pwrdn(pd_v[c]),
            .ref_evt(ref_v[c]), .active(act_v[c]), .thresh(lock_thresh),
            .locked(lock_v[c])
        );
    end

    monitor_select #(.NCH(NCH), .SEL_W(3)) u_mon (
        .clk(clk), .rst_n(rst_n), .sel(mon_sel),
        .ref_evt(ref_v), .fb_evt(fb_v), .locked(lock_v), .pwrdn(pd_v),
        .mon(mon_out)
    );

    assign up_a    = up_v[0];
    assign dn_a    = dn_v[0];
    assign drive_a = drv_v[0];
    assign up_b    = up_v[1];
    assign dn_b    = dn_v[1];
    assign drive_b = drv_v[1];
endmodule

// File: tb/dual_pfd_lock_bench.sv
module dual_pfd_lock_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_a = 0, fb_a = 0, ref_b = 0, fb_b = 0;
    logic invert_a = 0, invert_b = 0, pwrdn_a = 0, pwrdn_b = 0;
    logic [2:0] mon_sel = 3'd0;
    logic [7:0] lock_thresh = 8'd3;
    logic up_a, dn_a, drive_a, up_b, dn_b, drive_b, mon_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dual_pfd_lock u_dual_pfd_lock (
        .clk(clk), .rst_n(rst_n), .ref_a(ref_a), .fb_a(fb_a), .ref_b(ref_b), .fb_b(fb_b),
        .invert_a(invert_a), .invert_b(invert_b), .pwrdn_a(pwrdn_a), .pwrdn_b(pwrdn_b),
        .mon_sel(mon_sel), .lock_thresh(lock_thresh),
        .up_a(up_a), .dn_a(dn_a), .drive_a(drive_a),
        .up_b(up_b), .dn_b(dn_b), .drive_b(drive_b), .mon_out(mon_out)
    );

    // vector: {sel[2:0], ref_a, fb_a, ref_b, fb_b, expected mon}
    localparam int NVEC = 12;
    localparam logic [7:0] VEC [NVEC] = '{
        {3'b000, 4'b1111, 1'b0}, {3'b001, 4'b1000, 1'b1}, {3'b001, 4'b0111, 1'b0},
        {3'b010, 4'b0100, 1'b1}, {3'b010, 4'b1011, 1'b0}, {3'b011, 4'b0010, 1'b1},
        {3'b011, 4'b1101, 1'b0}, {3'b100, 4'b0001, 1'b1}, {3'b100, 4'b1110, 1'b0},
        {3'b101, 4'b1111, 1'b0}, {3'b110, 4'b1111, 1'b0}, {3'b111, 4'b1111, 1'b0}
    };

    task automatic chk(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic pulse(input logic ra, input logic fa, input logic rb, input logic fbb);
        ref_a = ra; fb_a = fa; ref_b = rb; fb_b = fbb;
        @(negedge clk);
        ref_a = 0; fb_a = 0; ref_b = 0; fb_b = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        chk(up_a, 1'b0, "R1 reset up_a");
        chk(dn_a, 1'b0, "R1 reset dn_a");
        chk(drive_a, 1'b0, "R1 reset drive_a");
        chk(drive_b, 1'b0, "R1 reset drive_b");
        chk(mon_out, 1'b0, "R7 reset mon unlocked");

        // R8 / R7: selector table, applied and withdrawn within one low phase
        for (int i = 0; i < NVEC; i++) begin
            mon_sel = VEC[i][7:5];
            {ref_a, fb_a, ref_b, fb_b} = VEC[i][4:1];
            #1;
            chk(mon_out, VEC[i][0], "R8 selector table");
            {ref_a, fb_a, ref_b, fb_b} = 4'b0000;
        end
        mon_sel = 3'd0;

        // R5: lock after four aligned periods on both channels
        do_reset();
        for (int k = 0; k < 3; k++) begin
            pulse(1, 1, 1, 1);
            chk(drive_a, 1'b0, "R1 aligned events leave pump idle");
            idle(2);
        end
        chk(mon_out, 1'b0, "R5 not locked after three periods");
        pulse(1, 1, 1, 1);
        chk(mon_out, 1'b1, "R5 locked after fourth period");

        // R7 / R9: power-down masking
        pwrdn_b = 1'b1;
        idle(1);
        chk(mon_out, 1'b1, "R7 powered-down channel ignored");
        pwrdn_a = 1'b1;
        idle(1);
        chk(mon_out, 1'b0, "R7 none powered gives low");
        pwrdn_a = 1'b0;
        idle(1);
        chk(mon_out, 1'b0, "R9 power-down cleared lock");

        // R2 / R3 / R4 on channel A, channel B powered down
        do_reset();
        pulse(1, 0, 0, 0);
        chk(up_a, 1'b1, "R2 ref first up_a");
        chk(dn_a, 1'b0, "R2 ref first dn_a");
        chk(drive_a, 1'b1, "R2 ref first drive_a");
        chk(drive_b, 1'b0, "R9 channel B held idle");
        pulse(0, 1, 0, 0);
        chk(drive_a, 1'b0, "R3 fb closes pulse");
        pulse(0, 1, 0, 0);
        chk(dn_a, 1'b1, "R2 fb first dn_a");
        chk(up_a, 1'b0, "R2 fb first up_a");
        pulse(1, 0, 0, 0);
        chk(drive_a, 1'b0, "R3 ref closes pulse");
        invert_a = 1'b1;
        pulse(1, 0, 0, 0);
        chk(dn_a, 1'b1, "R4 inverted ref first dn_a");
        chk(up_a, 1'b0, "R4 inverted ref first up_a");
        pulse(0, 1, 0, 0);
        invert_a = 1'b0;
        chk(drive_a, 1'b0, "R4 inverted pulse closed");

        // R6: pulse width boundary with threshold 3
        do_reset();
        for (int k = 0; k < 4; k++) begin
            pulse(1, 1, 0, 0);
            idle(1);
        end
        chk(mon_out, 1'b1, "R6 precondition locked");
        pulse(1, 0, 0, 0);
        idle(4);
        chk(mon_out, 1'b1, "R6 width equal to threshold plus one keeps lock");
        idle(1);
        chk(mon_out, 1'b0, "R6 wider pulse clears lock");
        pulse(0, 1, 0, 0);
        chk(drive_a, 1'b0, "R3 long pulse closed");

        // R9: power-down during an open pulse
        pulse(1, 0, 0, 0);
        chk(drive_a, 1'b1, "R9 precondition pulse open");
        pwrdn_a = 1'b1;
        idle(1);
        chk(drive_a, 1'b0, "R9 power-down forces high impedance");
        pwrdn_a = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule